// File: doc/BRIEF.md
# Indirect Coefficient RAM Loader

This block sits between a host register bus and a 24-bit coefficient RAM that feeds an audio filter datapath. The host never reaches the RAM directly. It programs a RAM address into one byte register and the upper, middle and lower bytes of a coefficient into three staging registers. It then sets a strobe bit in a control register. The loader moves the whole 24-bit word into the RAM in a single write cycle. A second strobe runs the other way: it copies the RAM word at the programmed address back into the three staging registers, where the host can read it one byte at a time.

Coefficients are signed two's-complement fractions. The most negative code (0x800000) stands for -1 and 0x7FFFFF for the largest value below +1. The RAM is split into one area per channel, and the areas are stored back to back. Each area holds five biquads of five terms, so a channel owns 25 consecutive words and channel c, term i sits at word c*25+i. The datapath reads through its own port by giving a channel and a term index. When the link bit in the control register is set, every channel is steered to channel 0's area, so one set of filters can serve all channels.

The datapath always has priority on the single RAM port. A host write or fetch that meets a datapath read is parked by a small state machine. Its states are IDLE, WR_HOLD, RD_HOLD and RD_LOAD. A commit strobe moves the machine from IDLE to WR_HOLD, and a fetch strobe moves it from IDLE to RD_HOLD. WR_HOLD returns to IDLE on the first cycle with no datapath read, and the RAM write happens in that cycle. RD_HOLD moves to RD_LOAD on the first cycle with no datapath read, and the RAM read happens in that cycle. RD_LOAD always returns to IDLE after loading the staging bytes.

Top module: `coef_loader`

## Requirements
- R1: After reset, every register offset reads 0x00, the link is off, and dp_valid is low.
- R2: The host register window uses reg_sel offsets 0 to 3. Offset 0 is the RAM address. Offset 1 is bits 23:16 of the staged word, offset 2 is bits 15:8 and offset 3 is bits 7:0. A byte written to any of these reads back unchanged on reg_rdata in the cycle after a reg_rd pulse.
- R3: Writing offset 4 with bit 0 set (commit) stores the staged word {offset1, offset2, offset3} at the staged address. This includes the extreme codes 0x800000 and 0x7FFFFF. Bits 0 and 1 of offset 4 always read back 0.
- R4: Writing offset 4 with bit 1 set (fetch) loads the RAM word at the staged address into offsets 1 to 3. With no datapath traffic, the bytes can be read from the third cycle after the strobe onward.
- R5: Bit 2 of offset 4 is the link bit. Every write to offset 4 sets it to bit 2 of the written value, and it reads back at bit 2.
- R6: A datapath read that asserts dp_rd_en with dp_chan and dp_idx returns the word at dp_chan*25+dp_idx on dp_data. dp_valid is high in the next cycle.
- R7: While the link bit is set, a datapath read returns the word at dp_idx, whatever dp_chan is. After the link bit is cleared, addressing by channel applies again.
- R8: A host RAM access never uses the RAM in a cycle with dp_rd_en high. A commit or fetch that meets datapath reads is deferred to the first cycle without one. During the wait the datapath reads the old word whole.
- R9: A commit or fetch strobe that arrives while an earlier one is still deferred is ignored. The staging registers stay writable in the meantime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe |
| reg_sel | input | 3 | Host register offset |
| reg_wdata | input | 8 | Host write byte |
| reg_rdata | output | 8 | Host read byte, valid the cycle after reg_rd |
| dp_rd_en | input | 1 | Datapath coefficient read request |
| dp_chan | input | 3 | Datapath channel number |
| dp_idx | input | 5 | Term index inside the channel area |
| dp_valid | output | 1 | dp_data holds the requested word |
| dp_data | output | 24 | Coefficient word to the datapath |

## Verification
Commits use the two extreme fraction codes and mixed byte patterns, at the first and last word of several channel areas. This tells byte ordering and area-stride mistakes apart from plain data faults. Datapath reads of one term index from two channels are done with the link bit on and then off, which separates the remapping from normal addressing. Long streams of datapath reads overlap a commit, a later staging write and a second commit. They show whether the write lands late but whole, and whether the second strobe is dropped. A fetch behind such a stream shows that the read path is deferred too.

// File: rtl/coef_loader_pkg.sv
package coef_loader_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WR_HOLD = 2'd1,
        ST_RD_HOLD = 2'd2,
        ST_RD_LOAD = 2'd3
    } ldr_state_e;

    localparam int OFF_ADDR  = 0;
    localparam int OFF_BYTE0 = 1;
    localparam int OFF_CTRL  = 4;

    localparam int BIT_COMMIT = 0;
    localparam int BIT_FETCH  = 1;
    localparam int BIT_LINK   = 2;

endpackage

// File: rtl/coef_ram.sv
module coef_ram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 24,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        if (re) begin
            rdata <= mem[addr];
        end
    end

endmodule

// File: rtl/coef_addr_map.sv
module coef_addr_map #(
    parameter int NUM_CH      = 6,
    parameter int COEF_PER_CH = 25,
    parameter int ADDR_W      = 8,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int IDX_W = (COEF_PER_CH > 1) ? $clog2(COEF_PER_CH) : 1
) (
    input  logic [CH_W-1:0]   chan,
    input  logic [IDX_W-1:0]  idx,
    input  logic              link,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] base;

    generate
        if (NUM_CH == 1) begin : g_single
            assign base = '0;
        end else begin : g_multi
            logic [CH_W-1:0] chan_eff;
            assign chan_eff = link ? '0 : chan;
            assign base     = ADDR_W'(int'(chan_eff) * COEF_PER_CH);
        end
    endgenerate

    assign addr = base + ADDR_W'(idx);

endmodule

// File: rtl/coef_stage_regs.sv
module coef_stage_regs
    import coef_loader_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 8,
    localparam int NBYTES = DATA_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_sel,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_word,
    output logic [ADDR_W-1:0] stage_addr,
    output logic [DATA_W-1:0] stage_word,
    output logic              link,
    output logic              commit_req,
    output logic              fetch_req
);

    logic [BYTE_W-1:0] byte_q [NBYTES];
    logic              ctrl_wr;
    logic [BYTE_W-1:0] rd_mux;

    assign ctrl_wr    = reg_wr && (reg_sel == 3'(OFF_CTRL));
    assign commit_req = ctrl_wr && reg_wdata[BIT_COMMIT];
    assign fetch_req  = ctrl_wr && reg_wdata[BIT_FETCH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_addr <= '0;
        end else if (reg_wr && (reg_sel == 3'(OFF_ADDR))) begin
            stage_addr <= reg_wdata[ADDR_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            link <= 1'b0;
        end else if (ctrl_wr) begin
            link <= reg_wdata[BIT_LINK];
        end
    end

    genvar k;
    generate
        for (k = 0; k < NBYTES; k++) begin : g_byte
            localparam int HI = DATA_W - 1 - k * BYTE_W;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    byte_q[k] <= '0;
                end else if (reg_wr && (reg_sel == 3'(OFF_BYTE0 + k))) begin
                    byte_q[k] <= reg_wdata;
                end else if (load_en) begin
                    byte_q[k] <= load_word[HI -: BYTE_W];
                end
            end
            assign stage_word[HI -: BYTE_W] = byte_q[k];
        end
    endgenerate

    always_comb begin
        rd_mux = '0;
        if (reg_sel == 3'(OFF_ADDR)) begin
            rd_mux = BYTE_W'(stage_addr);
        end else if (reg_sel == 3'(OFF_CTRL)) begin
            rd_mux = BYTE_W'({link, 2'b00});
        end else begin
            for (int i = 0; i < NBYTES; i++) begin
                if (reg_sel == 3'(OFF_BYTE0 + i)) begin
                    rd_mux = byte_q[i];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/coef_load_fsm.sv
module coef_load_fsm
    import coef_loader_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_req,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] stage_addr,
    input  logic [DATA_W-1:0] stage_word,
    input  logic              dp_busy,
    input  logic [DATA_W-1:0] ram_q,
    output logic              host_we,
    output logic              host_re,
    output logic [ADDR_W-1:0] host_addr,
    output logic [DATA_W-1:0] host_wdata,
    output logic              load_en,
    output logic [DATA_W-1:0] load_word,
    output ldr_state_e        state
);

    ldr_state_e        state_nx;
    logic [ADDR_W-1:0] pend_addr;
    logic [DATA_W-1:0] pend_word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_addr <= '0;
            pend_word <= '0;
        end else if ((state == ST_IDLE) && (commit_req || fetch_req)) begin
            pend_addr <= stage_addr;
            pend_word <= stage_word;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (commit_req) begin
                    state_nx = ST_WR_HOLD;
                end else if (fetch_req) begin
                    state_nx = ST_RD_HOLD;
                end
            end
            ST_WR_HOLD: begin
                if (!dp_busy) begin
                    state_nx = ST_IDLE;
                end
            end
            ST_RD_HOLD: begin
                if (!dp_busy) begin
                    state_nx = ST_RD_LOAD;
                end
            end
            ST_RD_LOAD: begin
                state_nx = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        host_we    = 1'b0;
        host_re    = 1'b0;
        load_en    = 1'b0;
        host_addr  = pend_addr;
        host_wdata = pend_word;
        load_word  = ram_q;
        unique case (state)
            ST_IDLE:    ;
            ST_WR_HOLD: host_we = !dp_busy;
            ST_RD_HOLD: host_re = !dp_busy;
            ST_RD_LOAD: load_en = 1'b1;
        endcase
    end

endmodule

// File: rtl/coef_loader.sv
module coef_loader
    import coef_loader_pkg::*;
#(
    parameter int NUM_CH      = 6,
    parameter int BIQUADS     = 5,
    parameter int TERMS       = 5,
    parameter int DATA_W      = 24,
    parameter int BYTE_W      = 8,
    parameter int ADDR_W      = 8,
    localparam int COEF_PER_CH = BIQUADS * TERMS,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int IDX_W = (COEF_PER_CH > 1) ? $clog2(COEF_PER_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_sel,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              dp_rd_en,
    input  logic [CH_W-1:0]   dp_chan,
    input  logic [IDX_W-1:0]  dp_idx,
    output logic              dp_valid,
    output logic [DATA_W-1:0] dp_data
);

    logic [ADDR_W-1:0] stage_addr;
    logic [DATA_W-1:0] stage_word;
    logic              link;
    logic              commit_req;
    logic              fetch_req;
    logic              load_en;
    logic [DATA_W-1:0] load_word;
    logic              host_we;
    logic              host_re;
    logic [ADDR_W-1:0] host_addr;
    logic [DATA_W-1:0] host_wdata;
    logic [ADDR_W-1:0] dp_ram_addr;
    logic [ADDR_W-1:0] ram_addr;
    logic [DATA_W-1:0] ram_q;
    ldr_state_e        state;

    coef_stage_regs #(
        .DATA_W(DATA_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .load_en(load_en), .load_word(load_word),
        .stage_addr(stage_addr), .stage_word(stage_word),
        .link(link), .commit_req(commit_req), .fetch_req(fetch_req)
    );

    coef_load_fsm #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .commit_req(commit_req), .fetch_req(fetch_req),
        .stage_addr(stage_addr), .stage_word(stage_word),
        .dp_busy(dp_rd_en), .ram_q(ram_q),
        .host_we(host_we), .host_re(host_re),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .load_en(load_en), .load_word(load_word),
        .state(state)
    );

    coef_addr_map #(
        .NUM_CH(NUM_CH), .COEF_PER_CH(COEF_PER_CH), .ADDR_W(ADDR_W)
    ) u_map (
        .chan(dp_chan), .idx(dp_idx), .link(link), .addr(dp_ram_addr)
    );

    assign ram_addr = dp_rd_en ? dp_ram_addr : host_addr;

    coef_ram #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_ram (
        .clk(clk), .we(host_we), .re(dp_rd_en | host_re),
        .addr(ram_addr), .wdata(host_wdata), .rdata(ram_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_valid <= 1'b0;
        end else begin
            dp_valid <= dp_rd_en;
        end
    end

    assign dp_data = ram_q;

endmodule

// File: rtl/coef_loader_chk.sv
module coef_loader_chk
    import coef_loader_pkg::*;
#(
    parameter int COEF_PER_CH = 25,
    parameter int ADDR_W      = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dp_rd_en,
    input logic              dp_valid,
    input logic              ram_we,
    input logic              link,
    input logic [ADDR_W-1:0] dp_ram_addr,
    input ldr_state_e        state,
    input logic              reg_rd,
    input logic [2:0]        reg_sel,
    input logic [7:0]        reg_rdata
);

    // R8: the host never writes the RAM in a datapath read cycle
    assert_no_collision_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> !dp_rd_en);

    // R8: a parked write stays parked while reads continue
    assert_hold_parked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WR_HOLD && dp_rd_en) |=> (state == ST_WR_HOLD));

    // R6: a datapath read answers one cycle later
    assert_dp_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dp_rd_en |=> dp_valid);

    assert_dp_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !dp_rd_en |=> !dp_valid);

    // R7: linked reads stay inside channel 0's area
    assert_link_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (link && dp_rd_en) |-> (int'(dp_ram_addr) < COEF_PER_CH));

    // R3: strobe bits read back as zero
    assert_strobe_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(reg_rd) && ($past(reg_sel) == 3'(OFF_CTRL))) |-> (reg_rdata[1:0] == 2'b00));

endmodule

bind coef_loader coef_loader_chk #(
    .COEF_PER_CH(COEF_PER_CH), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .dp_rd_en(dp_rd_en), .dp_valid(dp_valid),
    .ram_we(host_we), .link(link), .dp_ram_addr(dp_ram_addr), .state(state),
    .reg_rd(reg_rd), .reg_sel(reg_sel), .reg_rdata(reg_rdata)
);

// File: tb/coef_loader_tb_top.sv
module coef_loader_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        dp_rd_en = 1'b0;
    logic [2:0]  dp_chan = '0;
    logic [4:0]  dp_idx = '0;
    logic        dp_valid;
    logic [23:0] dp_data;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    bit link_m = 0;
    logic [23:0] model [256];
    logic [23:0] exp_q [$];
    string       req_q [$];

    always #10 clk = ~clk;

    coef_loader dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dp_rd_en(dp_rd_en), .dp_chan(dp_chan), .dp_idx(dp_idx),
        .dp_valid(dp_valid), .dp_data(dp_data)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(logic [2:0] sel, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(logic [2:0] sel, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_sel = sel;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic reg_expect(string req, logic [2:0] sel, logic [7:0] exp);
        logic [7:0] v;
        reg_read(sel, v);
        check(req, 32'(v), 32'(exp));
    endtask

    task automatic stage(logic [7:0] a, logic [23:0] w);
        reg_write(3'd0, a);
        reg_write(3'd1, w[23:16]);
        reg_write(3'd2, w[15:8]);
        reg_write(3'd3, w[7:0]);
    endtask

    task automatic load_coef(logic [7:0] a, logic [23:0] w);
        stage(a, w);
        reg_write(3'd4, {5'd0, link_m, 2'b01});
        model[a] = w;
    endtask

    function automatic int map_addr(int ch, int ix);
        return (link_m ? 0 : ch) * 25 + ix;
    endfunction

    task automatic dp_burst(string req, int n, int ch, int ix);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            dp_rd_en = 1'b1; dp_chan = 3'(ch); dp_idx = 5'(ix);
            exp_q.push_back(model[map_addr(ch, ix)]);
            req_q.push_back(req);
        end
        @(negedge clk);
        dp_rd_en = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && dp_valid) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R6 actual=%h expected=none (unexpected dp_valid)", dp_data);
            end else begin
                logic [23:0] e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                check(r, 32'(dp_data), 32'(e));
            end
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 dp_valid", 32'(dp_valid), 32'd0);
        for (int s = 0; s < 5; s++) reg_expect("R1 reg", 3'(s), 8'h00);

        // R2 staging readback
        stage(8'h11, 24'hA53C0F);
        reg_expect("R2 addr", 3'd0, 8'h11);
        reg_expect("R2 top", 3'd1, 8'hA5);
        reg_expect("R2 mid", 3'd2, 8'h3C);
        reg_expect("R2 low", 3'd3, 8'h0F);

        // R3 commits, extreme codes and area edges
        load_coef(8'd0, 24'h800000);
        load_coef(8'd24, 24'h7FFFFF);
        load_coef(8'd25, 24'h123456);
        load_coef(8'd149, 24'hABCDEF);
        load_coef(8'd30, 24'h000001);
        load_coef(8'd4, 24'h5A5A5A);
        load_coef(8'd79, 24'h0F0F0F);
        reg_expect("R3 strobe clear", 3'd4, 8'h00);

        // R6 channel addressing, R3 data landed
        dp_burst("R3 R6 c0i0", 1, 0, 0);
        dp_burst("R3 R6 c0i24", 1, 0, 24);
        dp_burst("R6 c1i0", 1, 1, 0);
        dp_burst("R6 c5i24", 1, 5, 24);
        dp_burst("R6 c1i5", 1, 1, 5);
        dp_burst("R6 c3i4", 1, 3, 4);

        // R5 / R7 link
        reg_write(3'd4, 8'h04);
        link_m = 1;
        reg_expect("R5 link set", 3'd4, 8'h04);
        dp_burst("R7 linked c3i4", 1, 3, 4);
        dp_burst("R7 linked c5i24", 1, 5, 24);
        reg_write(3'd4, 8'h00);
        link_m = 0;
        reg_expect("R5 link clear", 3'd4, 8'h00);
        dp_burst("R7 unlinked c3i4", 1, 3, 4);

        // R4 fetch
        stage(8'd149, 24'h000000);
        reg_write(3'd4, 8'h02);
        idle(1);
        reg_expect("R4 top", 3'd1, 8'hAB);
        reg_expect("R4 mid", 3'd2, 8'hCD);
        reg_expect("R4 low", 3'd3, 8'hEF);
        reg_expect("R4 strobe clear", 3'd4, 8'h00);

        // R8 / R9 commit deferred behind datapath reads
        load_coef(8'd60, 24'h010203);
        stage(8'd60, 24'h445566);
        fork
            dp_burst("R8 old word whole", 14, 2, 10);
            begin
                reg_write(3'd4, 8'h01);
                reg_write(3'd1, 8'h77);
                reg_write(3'd4, 8'h01);
            end
        join
        model[60] = 24'h445566;
        dp_burst("R8 R9 deferred commit landed", 1, 2, 10);
        reg_expect("R9 staging writable", 3'd1, 8'h77);

        // R8 fetch deferred behind datapath reads
        stage(8'd24, 24'h000000);
        fork
            dp_burst("R8 reads during fetch", 6, 0, 0);
            reg_write(3'd4, 8'h02);
        join
        idle(2);
        reg_expect("R8 fetch top", 3'd1, 8'h7F);
        reg_expect("R8 fetch mid", 3'd2, 8'hFF);
        reg_expect("R8 fetch low", 3'd3, 8'hFF);

        idle(3);
        check("R6 scoreboard drained", 32'(exp_q.size()), 32'd0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule